// File: doc/BRIEF.md
# Pulse-Width Bit Demodulator

This block takes the raw data line of an on-off-keyed radio receiver and turns it into decoded bits. Each symbol is a high pulse followed by a low pulse. The width of the high pulse carries the bit value, and the low pulse acts as a separator whose width must fall inside a fixed window. The line is asynchronous, so it is first brought into the clock domain. Every edge is then timed with a counter that advances on a one-microsecond tick enable.

The block stores the high width when the falling edge arrives. It decides nothing until the next rising edge closes the low pulse. At that point both widths are judged. A symbol that passes gives a one-cycle bit strobe with the bit value. Any width outside its window discards the symbol silently, so radio noise produces no output.

A gap timer watches the spacing between accepted bits. When too much time passes, it pulses a timeout for the frame logic and drops any high pulse still waiting for its low pulse.

Top module: `pwm_bit_demod`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `bit_valid` and `gap_timeout` are 0. A reset also disarms the gap timer, so a long idle line after reset gives no timeout.
- R2: `rf_in` passes through two synchroniser flops. The bit strobe for a symbol is seen in the third clock cycle after the cycle in which `rf_in` rises at the end of that symbol's low pulse.
- R3: Widths are counted in `tick_us` periods, not in clock cycles. A clock edge with `tick_us` low does not advance any width or gap count.
- R4: A high pulse of 300 to 700 ticks inclusive, with a valid low pulse after it, decodes as `bit_value` 0.
- R5: A high pulse of 800 to 1200 ticks inclusive, with a valid low pulse after it, decodes as `bit_value` 1. Any other high width (for example 299, 701, 799 or 1201) gives no strobe.
- R6: The low pulse is valid only when it lasts 300 to 700 ticks inclusive. A low of 299 or 701 ticks gives no strobe, whatever the high width was.
- R7: A symbol is judged only at the rising edge that closes its low pulse. A high pulse that is never followed by a rising edge produces nothing.
- R8: The gap timer arms on each accepted bit. If more than 2500 ticks pass after that bit with no new accepted bit, `gap_timeout` pulses for exactly one cycle, and the timer then stays quiet until the next accepted bit.
- R9: When the gap timer expires after a falling edge has latched a high width, that stored width is discarded, so the rising edge that follows gives no strobe.
- R10: If a bit is accepted in the same cycle the gap limit is reached, the bit wins. It is strobed, no timeout is issued, and the gap count restarts.
- R11: The width counters saturate at their maximum instead of wrapping. A width of 4096 plus a valid width (for example 4596 or 4396) never aliases into a valid symbol.
- R12: `bit_valid` is never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_us | input | 1 | One-cycle enable, once per microsecond |
| rf_in | input | 1 | Asynchronous raw data from the radio receiver |
| bit_valid | output | 1 | One-cycle strobe: a symbol was accepted |
| bit_value | output | 1 | Decoded value, meaningful while `bit_valid` is high |
| gap_timeout | output | 1 | One-cycle strobe: the inter-bit gap exceeded its limit |

## Verification
The accept path and the gap timer can act on the same clock edge. The bench provokes this by placing a rejected noise symbol after an accepted bit, then a valid symbol whose closing rising edge lands exactly 2501 ticks after the previous accept; it expects a strobe with value 1 and no timeout. The same pattern stretched by one tick must instead give a timeout with no strobe, because the stored high width has been dropped. A reference model in the bench also reproduces both orderings, and the case where the timeout and a falling edge share a cycle, over a random symbol stream.

// File: rtl/pwm_demod_pkg.sv
package pwm_demod_pkg;

  typedef enum logic [1:0] {
    SYM_NONE = 2'd0,
    SYM_ZERO = 2'd1,
    SYM_ONE  = 2'd2
  } sym_e;

  // Inclusive window test on a measured width.
  function automatic logic in_window(input logic [31:0] v,
                                     input int unsigned lo,
                                     input int unsigned hi);
    return (v >= lo) && (v <= hi);
  endfunction

  // Map a high-pulse width onto a symbol class.
  function automatic sym_e classify_high(input logic [31:0] len,
                                         input int unsigned z_lo,
                                         input int unsigned z_hi,
                                         input int unsigned o_lo,
                                         input int unsigned o_hi);
    if (in_window(len, z_lo, z_hi)) return SYM_ZERO;
    if (in_window(len, o_lo, o_hi)) return SYM_ONE;
    return SYM_NONE;
  endfunction

endpackage

// File: rtl/pwm_edge_sync.sv
module pwm_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise,
  output logic fall
);

  // Element i holds the input delayed by i+1 clocks; the last one is the
  // previous synchronised level, used for edge detection.
  logic [STAGES:0] chain;

  genvar g;
  generate
    for (g = 0; g <= STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= 1'b0;
          else     chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign rise =  chain[STAGES-1] & ~chain[STAGES];
  assign fall = ~chain[STAGES-1] &  chain[STAGES];

endmodule

// File: rtl/pwm_run_counter.sv
module pwm_run_counter #(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         restart,
  output logic [W-1:0] count
);

  localparam logic [W-1:0] CMAX = {W{1'b1}};

  // On an edge the new level starts; the edge cycle itself counts when it
  // carries a tick. The count then holds at CMAX instead of wrapping.
  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (restart) begin
      count <= {{(W-1){1'b0}}, tick};
    end else if (tick && (count != CMAX)) begin
      count <= count + 1'b1;
    end
  end

endmodule

// File: rtl/pwm_gap_timer.sv
module pwm_gap_timer #(
  parameter int unsigned LIMIT = 2500
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic accept,
  output logic expire,
  output logic timeout
);

  localparam int unsigned GW = $clog2(LIMIT + 1);
  localparam logic [GW-1:0] LIM = GW'(LIMIT);

  logic          armed;
  logic [GW-1:0] gap;

  // Expiry happens on the tick after the count has reached LIMIT, so the
  // limit must be exceeded. An accept in the same cycle takes priority.
  assign expire = armed && tick && !accept && (gap == LIM);

  always_ff @(posedge clk) begin
    if (rst) begin
      armed   <= 1'b0;
      gap     <= '0;
      timeout <= 1'b0;
    end else begin
      timeout <= expire;
      if (accept) begin
        armed <= 1'b1;
        gap   <= '0;
      end else if (expire) begin
        armed <= 1'b0;
      end else if (armed && tick && (gap != LIM)) begin
        gap <= gap + 1'b1;
      end
    end
  end

endmodule

// File: rtl/pwm_bit_demod.sv
module pwm_bit_demod
  import pwm_demod_pkg::*;
#(
  parameter int unsigned CNT_W       = 12,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned LOW_MIN     = 300,
  parameter int unsigned LOW_MAX     = 700,
  parameter int unsigned ZERO_MIN    = 300,
  parameter int unsigned ZERO_MAX    = 700,
  parameter int unsigned ONE_MIN     = 800,
  parameter int unsigned ONE_MAX     = 1200,
  parameter int unsigned GAP_LIMIT   = 2500
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_us,
  input  logic rf_in,
  output logic bit_valid,
  output logic bit_value,
  output logic gap_timeout
);

  logic             rise;
  logic             fall;
  logic [CNT_W-1:0] run_len;
  logic [CNT_W-1:0] hi_len;
  logic             hi_valid;
  sym_e             hi_cls;
  logic             low_ok;
  logic             accept;
  logic             expire;

  pwm_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (rf_in),
    .rise (rise),
    .fall (fall)
  );

  // One counter times whichever level is current; it restarts on every edge.
  pwm_run_counter #(.W(CNT_W)) u_run (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick_us),
    .restart (rise | fall),
    .count   (run_len)
  );

  assign hi_cls = classify_high(32'(hi_len), ZERO_MIN, ZERO_MAX, ONE_MIN, ONE_MAX);
  assign low_ok = in_window(32'(run_len), LOW_MIN, LOW_MAX);
  assign accept = rise && hi_valid && low_ok && (hi_cls != SYM_NONE);

  pwm_gap_timer #(.LIMIT(GAP_LIMIT)) u_gap (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick_us),
    .accept  (accept),
    .expire  (expire),
    .timeout (gap_timeout)
  );

  // The high width is stored at the falling edge and judged at the next
  // rising edge. A falling edge in the same cycle as an expiry keeps its width.
  always_ff @(posedge clk) begin
    if (rst) begin
      hi_len    <= '0;
      hi_valid  <= 1'b0;
      bit_valid <= 1'b0;
      bit_value <= 1'b0;
    end else begin
      bit_valid <= accept;
      if (accept) bit_value <= (hi_cls == SYM_ONE);
      if (fall) begin
        hi_len   <= run_len;
        hi_valid <= 1'b1;
      end else if (rise || expire) begin
        hi_valid <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/pwm_bit_demod_chk.sv
module pwm_bit_demod_chk #(
  parameter int unsigned GAP_LIMIT = 2500
) (
  input logic clk,
  input logic rst,
  input logic tick_us,
  input logic bit_valid,
  input logic gap_timeout
);

  logic        armed_q;
  int unsigned ticks_q;

  // Observed state: armed by a seen strobe, disarmed by a seen timeout;
  // ticks counted since the last strobe, held just above the limit.
  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b0;
      ticks_q <= 0;
    end else begin
      if (bit_valid)        armed_q <= 1'b1;
      else if (gap_timeout) armed_q <= 1'b0;
      if (bit_valid)                          ticks_q <= 0;
      else if (tick_us && ticks_q <= GAP_LIMIT) ticks_q <= ticks_q + 1;
    end
  end

  p_bit_single_r12: assert property (@(posedge clk) disable iff (rst)
    bit_valid |=> !bit_valid);

  p_tmo_single_r8: assert property (@(posedge clk) disable iff (rst)
    gap_timeout |=> !gap_timeout);

  p_tmo_needs_bit_r8: assert property (@(posedge clk) disable iff (rst)
    gap_timeout |-> armed_q);

  p_tmo_after_limit_r8: assert property (@(posedge clk) disable iff (rst)
    gap_timeout |-> (ticks_q + 1 >= GAP_LIMIT));

  p_bit_beats_tmo_r10: assert property (@(posedge clk) disable iff (rst)
    !(bit_valid && gap_timeout));

endmodule

bind pwm_bit_demod pwm_bit_demod_chk #(.GAP_LIMIT(GAP_LIMIT)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .tick_us     (tick_us),
  .bit_valid   (bit_valid),
  .gap_timeout (gap_timeout)
);

// File: tb/tb_pwm_bit_demod.sv
module tb_pwm_bit_demod;

  localparam int LIM1 = 2501;   // ticks after an accept when the timeout fires

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_us = 1'b0;
  logic rf_in = 1'b0;
  logic bit_valid, bit_value, gap_timeout;

  pwm_bit_demod dut (
    .clk         (clk),
    .rst         (rst),
    .tick_us     (tick_us),
    .rf_in       (rf_in),
    .bit_valid   (bit_valid),
    .bit_value   (bit_value),
    .gap_timeout (gap_timeout)
  );

  always #2 clk = ~clk;

  int vectors = 0;
  int miscompares = 0;
  int cyc = 0;
  int rise_cyc = 0;
  int div = 1;
  int phase = 0;
  int exp_bits[$];
  int exp_tmo = 0;
  int seen_tmo = 0;
  bit done = 1'b0;

  // reference model state
  bit m_armed = 1'b0;
  int m_e = 0;
  bit have_prev = 1'b0;
  int prev_h = 0;
  int prev_l = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  // Monitor: outputs only change at posedge, sampled here at negedge.
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (bit_valid) begin
        if (exp_bits.size() == 0) begin
          chk(1'b0, "R4 or R5 unexpected strobe", int'(bit_value), -1);
        end else begin
          int e;
          e = exp_bits.pop_front();
          chk(int'(bit_value) == e, "R4 or R5 bit value", int'(bit_value), e);
          chk(cyc - rise_cyc == 3, "R2 strobe latency", cyc - rise_cyc, 3);
        end
      end
      if (gap_timeout) seen_tmo++;
    end
  end

  task automatic step();
    @(negedge clk);
    phase++;
    tick_us = ((phase % div) == 0);
  endtask

  task automatic drive(input bit lvl, input int n);
    for (int i = 0; i < n; i++) begin
      step();
      if (i == 0) begin
        rf_in = lvl;
        if (lvl) rise_cyc = cyc;
      end
    end
  endtask

  function automatic int hclass(input int h);
    if (h >= 300 && h <= 700)  return 0;
    if (h >= 800 && h <= 1200) return 1;
    return -1;
  endfunction

  // Judge a finished symbol (widths in ticks) at its closing rising edge.
  task automatic evaluate(input int h, input int l);
    int tf, tr;
    bit pend, ok;
    tf = m_e + h;
    tr = m_e + h + l;
    pend = 1'b1;
    if (m_armed && tr > LIM1) begin
      exp_tmo++;
      m_armed = 1'b0;
      if (tf < LIM1) pend = 1'b0;            // R9 stored width dropped
    end
    ok = pend && (hclass(h) >= 0) && (l >= 300) && (l <= 700);
    if (ok) begin
      exp_bits.push_back(hclass(h));
      m_armed = 1'b1;
      m_e = 0;
    end else begin
      if (m_armed && tr == LIM1) begin
        exp_tmo++;
        m_armed = 1'b0;
      end
      m_e = tr;
    end
  endtask

  task automatic send(input int h, input int l);
    if (have_prev) evaluate(prev_h, prev_l);
    drive(1'b1, h * div);
    drive(1'b0, l * div);
    prev_h = h;
    prev_l = l;
    have_prev = 1'b1;
  endtask

  task automatic end_block(input string req);
    send(50, 3000);                          // R7: trailing high never judged
    if (m_armed) begin
      exp_tmo++;
      m_armed = 1'b0;
    end
    repeat (10) step();
    chk(exp_bits.size() == 0, {req, " missing strobes"}, exp_bits.size(), 0);
    chk(seen_tmo == exp_tmo, {req, " timeout count (R8)"}, seen_tmo, exp_tmo);
    exp_bits.delete();
    seen_tmo = exp_tmo;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (5) step();
    chk(bit_valid == 1'b0 && gap_timeout == 1'b0, "R1 outputs in reset",
        int'(bit_valid) + int'(gap_timeout), 0);
    rst = 1'b0;
    step();
    chk(bit_valid == 1'b0 && gap_timeout == 1'b0, "R1 outputs after reset",
        int'(bit_valid) + int'(gap_timeout), 0);
    repeat (20) step();

    // R4 / R5: high-width boundaries, each with a 500-tick low
    send(300, 500); send(299, 500); send(700, 500); send(701, 500);
    send(800, 500); send(799, 500); send(1200, 500); send(1201, 500);
    send(500, 500);
    end_block("R5 high windows");

    // R6: low-width boundaries
    send(500, 300); send(500, 299); send(1000, 700); send(1000, 701);
    send(1000, 300); send(500, 700);
    end_block("R6 low windows");

    // R10: accept lands exactly on the gap limit
    send(500, 500); send(200, 600); send(1200, 501);
    // R9: one tick later, the timeout drops the stored width
    send(500, 500); send(200, 600); send(1200, 502);
    send(500, 500); send(1000, 500);
    end_block("R10 and R9 same-cycle order");

    // R11: saturation prevents wrap-around aliasing
    send(500, 500); send(500, 4596); send(4396, 500); send(500, 500);
    send(1000, 500);
    end_block("R11 saturation");

    // R3: tick every other cycle; widths are in ticks, not cycles
    div = 2;
    send(500, 500); send(400, 400); send(1000, 500); send(600, 400);
    end_block("R3 tick gating");
    div = 1;

    // R1: reset disarms the gap timer
    send(500, 500); send(500, 500);
    repeat (5) step();
    rst = 1'b1;
    repeat (4) step();
    rst = 1'b0;
    m_armed = 1'b0;
    have_prev = 1'b0;
    repeat (3000) step();
    chk(seen_tmo == exp_tmo, "R1 no timeout after reset", seen_tmo, exp_tmo);
    chk(exp_bits.size() == 0, "R1 strobes before reset", exp_bits.size(), 0);
    exp_bits.delete();
    seen_tmo = exp_tmo;

    // Random symbol stream around the windows
    for (int i = 0; i < 40; i++) begin
      send(int'($urandom_range(1300, 250)), int'($urandom_range(800, 250)));
    end
    end_block("R8 random stream");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule